// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block gathers six interrupt sources for a small CPU: three external pins and three one-cycle request strobes from on-chip peripherals (timer 1, timer 2A and the analog converter). Each source owns a sticky pending flag, a local enable and a chain-select bit. The chain-select bit places the source on the high-priority chain (level 1) or the low-priority chain (level 2). Inside each chain the order is fixed. The external pins pass through a synchroniser and an edge detector whose polarity is chosen per pin. External input 1 can be turned into a non-maskable source, but only while the privilege input is high.

The CPU sees two request lines, one per level, and the vector address of the overall winner. The CPU drives its global level masks in from its status register. It signals an instruction boundary with a one-cycle strobe. A controller state machine takes a request only on that strobe. It then produces a one-cycle acknowledge that names the serviced source and clears its flag.

The controller has three states. In IDLE no enabled request is visible. The IDLE-to-PEND transition happens when any eligible request appears. In PEND the request lines are driven. PEND-to-IDLE happens if the request disappears, for example when a mask drops. PEND-to-GRANT happens on the boundary strobe, and the winner is latched at that point. GRANT lasts one cycle with acknowledge high, then the fixed GRANT-to-IDLE transition follows.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With `ext_rise[i]`=1, a 0-to-1 transition on `ext_pin[i]` sets flag bit i within five cycles. A 1-to-0 transition on that pin sets nothing.
- R2: With `ext_rise[i]`=0, a 1-to-0 transition on `ext_pin[i]` sets flag bit i. A 0-to-1 transition sets nothing.
- R3: Flag bits 0..2 belong to external inputs 1..3. Bits 3, 4 and 5 belong to timer 1, timer 2A and the converter. A one-cycle high on `periph_req[k]` sets flag bit 3+k. Flags stay set until serviced and show on `flags` whatever the enables.
- R4: A set flag whose `src_en` bit is 0 raises neither request line.
- R5: `chain_sel[i]`=1 puts source i on level 1 (`irq_hi`) and 0 puts it on level 2 (`irq_lo`). When both levels request, the vector shown is the level-1 winner's.
- R6: `ie1`=0 blocks level 1 and `ie2`=0 blocks level 2, each independently of the other.
- R7: Within one chain the lowest flag index wins: external 1, external 2, external 3, timer 1, timer 2A, converter.
- R8: The vector addresses are 7FFC, 7FFA and 7FF8 for the external inputs 1..3, 7FF4 for timer 1, 7FEE for timer 2A and 7FEC for the converter. `vec_addr` is 0 when nothing is requested.
- R9: A request is taken only when `instr_end` is high while it is raised. In the next cycle `ack` is high for exactly one cycle with `ack_src` set to the flag index. The flag is clear in the cycle after that.
- R10: `nmi_mode` loads `nmi_wdata` on `nmi_wr` only while `priv` is high. While it is set, a pending flag 0 drives `irq_hi` regardless of `src_en[0]`, `chain_sel[0]` and `ie1`.
- R11: After reset, flags, `nmi_mode`, `irq_hi`, `irq_lo`, `ack` and `vec_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| periph_req | input | 3 | One-cycle peripheral request strobes (timer 1, timer 2A, converter) |
| src_en | input | 6 | Local enable per source |
| chain_sel | input | 6 | 1 = level 1 chain, 0 = level 2 chain |
| ext_rise | input | 3 | Edge polarity per pin: 1 rising, 0 falling |
| ie1 | input | 1 | Global level-1 mask (1 = allowed) |
| ie2 | input | 1 | Global level-2 mask (1 = allowed) |
| priv | input | 1 | Privilege qualifier for NMI configuration writes |
| nmi_wr | input | 1 | Write strobe for the NMI mode bit |
| nmi_wdata | input | 1 | Value written to the NMI mode bit |
| instr_end | input | 1 | CPU instruction-boundary strobe |
| irq_hi | output | 1 | Level-1 request to the CPU |
| irq_lo | output | 1 | Level-2 request to the CPU |
| vec_addr | output | 16 | Vector address (high-byte location) of the winner |
| ack | output | 1 | One-cycle acknowledge of an accepted request |
| ack_src | output | 3 | Flag index being acknowledged |
| flags | output | 6 | Pending flags |
| nmi_mode | output | 1 | External input 1 is non-maskable |

## Verification
The hardest situation to reach is the NMI path. A pending input-1 flag has to reach the CPU while its local enable, its chain choice and the level-1 mask all say no. That situation needs a guarded configuration bit that an unprivileged write must fail to change. The bench first clears all three qualifiers and tries the write without privilege. It then raises the pin and checks that both request lines stay low. Only after a privileged write does it expect the level-1 request with the input-1 vector. A second awkward case is a higher-index level-1 source beating a lower-index level-2 source. The bench sets this up with one pin edge and one peripheral strobe, then services both in turn to see the order flip back.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 6;
    localparam int NEXT = 3;
    localparam int IDW  = $clog2(NSRC);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_GRANT = 2'd2
    } arb_state_e;

    function automatic logic [15:0] vec_of(input logic [IDW-1:0] id);
        logic [15:0] v;
        unique case (id)
            3'd0:    v = 16'h7FFC;
            3'd1:    v = 16'h7FFA;
            3'd2:    v = 16'h7FF8;
            3'd3:    v = 16'h7FF4;
            3'd4:    v = 16'h7FEE;
            3'd5:    v = 16'h7FEC;
            default: v = 16'h7FFE;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_i,
    output logic hit_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        if (rise_i) hit_o = sync_q[STAGES-1] & ~last_q;
        else        hit_o = ~sync_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int W   = 6,
    parameter int IDW = 3
) (
    input  logic [W-1:0]   req_i,
    output logic           any_o,
    output logic [IDW-1:0] id_o
);
    always_comb begin
        id_o  = '0;
        any_o = |req_i;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) id_o = IDW'(i);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_pin,
    input  logic [NSRC-NEXT-1:0] periph_req,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] chain_sel,
    input  logic [NEXT-1:0] ext_rise,
    input  logic            ie1,
    input  logic            ie2,
    input  logic            priv,
    input  logic            nmi_wr,
    input  logic            nmi_wdata,
    input  logic            instr_end,
    output logic            irq_hi,
    output logic            irq_lo,
    output logic [15:0]     vec_addr,
    output logic            ack,
    output logic [IDW-1:0]  ack_src,
    output logic [NSRC-1:0] flags,
    output logic            nmi_mode
);
    arb_state_e      state_q, state_d;
    logic [NEXT-1:0] ext_hit;
    logic [NSRC-1:0] set_v, clr_v, elig, hi_vec, lo_vec;
    logic            hi_any, lo_any, any_req, nmi_pend;
    logic [IDW-1:0]  hi_id, lo_id, win_id, grant_q;

    // edge detection, one per external pin
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_pin[g]),
            .rise_i (ext_rise[g]),
            .hit_o  (ext_hit[g])
        );
    end

    assign set_v = {periph_req, ext_hit};

    always_comb begin
        clr_v = '0;
        if (state_q == ST_GRANT) clr_v[grant_q] = 1'b1;
    end

    // sticky flags: a new event in the clearing cycle survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= set_v | (flags & ~clr_v);
    end

    // guarded NMI configuration bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               nmi_mode <= 1'b0;
        else if (nmi_wr && priv)  nmi_mode <= nmi_wdata;
    end

    // chain formation
    always_comb begin
        nmi_pend = nmi_mode & flags[0];
        elig     = flags & src_en;
        hi_vec   = elig & chain_sel & {NSRC{ie1}};
        lo_vec   = elig & ~chain_sel & {NSRC{ie2}};
        if (nmi_mode) begin
            hi_vec[0] = nmi_pend;
            lo_vec[0] = 1'b0;
        end
    end

    irq_pick #(.W(NSRC), .IDW(IDW)) u_pick_hi (
        .req_i (hi_vec), .any_o (hi_any), .id_o (hi_id)
    );
    irq_pick #(.W(NSRC), .IDW(IDW)) u_pick_lo (
        .req_i (lo_vec), .any_o (lo_any), .id_o (lo_id)
    );

    assign any_req = hi_any | lo_any;
    assign win_id  = hi_any ? hi_id : lo_id;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PEND && any_req && instr_end) grant_q <= win_id;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_req) state_d = ST_PEND;
            ST_PEND: begin
                if (!any_req)       state_d = ST_IDLE;
                else if (instr_end) state_d = ST_GRANT;
            end
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_hi   = 1'b0;
        irq_lo   = 1'b0;
        ack      = 1'b0;
        ack_src  = grant_q;
        vec_addr = 16'h0000;
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: begin
                irq_hi   = hi_any;
                irq_lo   = lo_any;
                if (any_req) vec_addr = vec_of(win_id);
            end
            ST_GRANT: begin
                ack      = 1'b1;
                vec_addr = vec_of(grant_q);
            end
            default: ;
        endcase
    end

    // R9: acknowledge is a single-cycle pulse
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R9: acknowledge only follows a boundary strobe
    p_ack_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(instr_end));
    // R9: the serviced source is still pending while acknowledged
    p_ack_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> flags[ack_src]);
    // R10: NMI mode changes only under privilege
    p_nmi_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_mode != $past(nmi_mode)) |-> $past(priv && nmi_wr));
    // R6: level-2 request never shown while its mask is off
    p_lo_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> ie2);
    // R4: a level-1 request needs an enabled level-1 flag or the NMI
    p_hi_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (((flags & src_en & chain_sel) != '0) || (nmi_mode && flags[0])));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_pin = '0;
    logic [2:0]  periph_req = '0;
    logic [5:0]  src_en = 6'h3F;
    logic [5:0]  chain_sel = '0;
    logic [2:0]  ext_rise = 3'b111;
    logic        ie1 = 1'b1, ie2 = 1'b1;
    logic        priv = 1'b0, nmi_wr = 1'b0, nmi_wdata = 1'b0;
    logic        instr_end = 1'b0;
    logic        irq_hi, irq_lo, ack, nmi_mode;
    logic [15:0] vec_addr;
    logic [2:0]  ack_src;
    logic [5:0]  flags;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .periph_req(periph_req),
        .src_en(src_en), .chain_sel(chain_sel), .ext_rise(ext_rise),
        .ie1(ie1), .ie2(ie2), .priv(priv), .nmi_wr(nmi_wr), .nmi_wdata(nmi_wdata),
        .instr_end(instr_end), .irq_hi(irq_hi), .irq_lo(irq_lo), .vec_addr(vec_addr),
        .ack(ack), .ack_src(ack_src), .flags(flags), .nmi_mode(nmi_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic accept();
        instr_end = 1'b1;
        cyc(1);
        instr_end = 1'b0;
    endtask

    task automatic pulse_periph(input int k);
        periph_req[k] = 1'b1;
        cyc(1);
        periph_req[k] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 flags", flags, 0);
        chk("R11 irq_hi", irq_hi, 0);
        chk("R11 irq_lo", irq_lo, 0);
        chk("R11 vec", vec_addr, 0);
        chk("R11 ack", ack, 0);
        chk("R11 nmi_mode", nmi_mode, 0);
    endtask

    task automatic t_rise();
        ext_pin[1] = 1'b1; cyc(5);
        chk("R1 rising sets flag", flags, 6'b000010);
        chk("R5 level2 request", irq_lo, 1);
        chk("R8 vector ext2", vec_addr, 16'h7FFA);
        accept();
        chk("R9 ack", ack, 1);
        chk("R9 ack_src", ack_src, 1);
        cyc(1);
        chk("R9 ack one cycle", ack, 0);
        chk("R9 flag cleared", flags, 0);
        ext_pin[1] = 1'b0; cyc(5);
        chk("R1 falling ignored", flags, 0);
    endtask

    task automatic t_fall();
        ext_rise[2] = 1'b0;
        ext_pin[2] = 1'b1; cyc(5);
        chk("R2 rising ignored", flags, 0);
        ext_pin[2] = 1'b0; cyc(5);
        chk("R2 falling sets flag", flags, 6'b000100);
        chk("R8 vector ext3", vec_addr, 16'h7FF8);
        accept(); cyc(1);
        ext_rise[2] = 1'b1;
    endtask

    task automatic t_enable();
        src_en[5] = 1'b0;
        pulse_periph(2); cyc(3);
        chk("R3 converter flag", flags, 6'b100000);
        chk("R4 no irq_lo", irq_lo, 0);
        chk("R4 no irq_hi", irq_hi, 0);
        src_en[5] = 1'b1; cyc(2);
        chk("R4 enabled irq_lo", irq_lo, 1);
        chk("R8 vector converter", vec_addr, 16'h7FEC);
        accept(); cyc(1);
        chk("R9 converter cleared", flags, 0);
    endtask

    task automatic t_levels();
        chain_sel[3] = 1'b1;
        ext_pin[0] = 1'b1;
        pulse_periph(0); cyc(5);
        chk("R5 irq_hi", irq_hi, 1);
        chk("R5 irq_lo", irq_lo, 1);
        chk("R5 level1 vector timer1", vec_addr, 16'h7FF4);
        accept();
        chk("R5 ack_src timer1", ack_src, 3);
        cyc(2);
        chk("R5 irq_hi dropped", irq_hi, 0);
        chk("R8 vector ext1", vec_addr, 16'h7FFC);
        accept();
        chk("R9 ack_src ext1", ack_src, 0);
        cyc(1);
        ext_pin[0] = 1'b0; chain_sel = '0; cyc(5);
        chk("R1 all clear", flags, 0);
    endtask

    task automatic t_order();
        ext_pin[2] = 1'b1;
        periph_req[1] = 1'b1; periph_req[2] = 1'b1; cyc(1);
        periph_req = '0; cyc(5);
        chk("R7 ext3 first", vec_addr, 16'h7FF8);
        accept(); cyc(2);
        chk("R7 timer2A next", vec_addr, 16'h7FEE);
        accept(); cyc(2);
        chk("R7 converter last", vec_addr, 16'h7FEC);
        accept(); cyc(1);
        ext_pin[2] = 1'b0; cyc(5);
        chk("R7 drained", flags, 0);
    endtask

    task automatic t_mask();
        chain_sel[4] = 1'b1; ie1 = 1'b0;
        pulse_periph(1); cyc(3);
        chk("R6 ie1 blocks", irq_hi, 0);
        chk("R6 flag kept", flags, 6'b010000);
        ie2 = 1'b0;
        pulse_periph(2); cyc(3);
        chk("R6 ie2 blocks", irq_lo, 0);
        ie1 = 1'b1; cyc(2);
        chk("R6 ie1 opens", irq_hi, 1);
        chk("R6 lo still masked", irq_lo, 0);
        chk("R8 vector timer2A", vec_addr, 16'h7FEE);
        accept();
        chk("R9 ack_src timer2A", ack_src, 4);
        cyc(1);
        ie2 = 1'b1; cyc(2);
        chk("R6 ie2 opens", irq_lo, 1);
        accept(); cyc(1);
        chain_sel = '0;
    endtask

    task automatic t_boundary();
        pulse_periph(0); cyc(3);
        chk("R9 pending", irq_lo, 1);
        cyc(4);
        chk("R9 no ack without boundary", ack, 0);
        chk("R9 flag held", flags, 6'b001000);
        accept();
        chk("R9 ack on boundary", ack, 1);
        cyc(1);
    endtask

    task automatic t_nmi();
        src_en[0] = 1'b0; ie1 = 1'b0; ie2 = 1'b0; chain_sel[0] = 1'b0;
        nmi_wr = 1'b1; nmi_wdata = 1'b1; cyc(1); nmi_wr = 1'b0; cyc(1);
        chk("R10 unprivileged write ignored", nmi_mode, 0);
        ext_pin[0] = 1'b1; cyc(5);
        chk("R10 flag set", flags, 6'b000001);
        chk("R10 blocked hi", irq_hi, 0);
        chk("R10 blocked lo", irq_lo, 0);
        priv = 1'b1; nmi_wr = 1'b1; cyc(1); nmi_wr = 1'b0; priv = 1'b0;
        chk("R10 privileged write", nmi_mode, 1);
        cyc(2);
        chk("R10 nmi on irq_hi", irq_hi, 1);
        chk("R10 nmi vector", vec_addr, 16'h7FFC);
        accept();
        chk("R10 ack_src", ack_src, 0);
        cyc(1);
        priv = 1'b1; nmi_wr = 1'b1; nmi_wdata = 1'b0; cyc(1);
        nmi_wr = 1'b0; priv = 1'b0; ext_pin[0] = 1'b0;
        src_en = 6'h3F; ie1 = 1'b1; ie2 = 1'b1; cyc(5);
        chk("R10 nmi cleared", nmi_mode, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_rise();
        t_fall();
        t_enable();
        t_levels();
        t_order();
        t_mask();
        t_boundary();
        t_nmi();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule